// File: doc/BRIEF.md
# MSI Message Interrupt Decoder

This block receives a message-signalled interrupt write, presented as a 64-bit address word and a 64-bit data word qualified by a single-cycle strobe. It confirms that the low half of the address targets the local interrupt controller window. For a write that hits the window, it extracts the destination ID, the destination mode, the delivery mode and the vector. It hands these fields to a downstream destination resolver as a one-cycle request.

A write that misses the window is discarded and reported with a one-cycle error pulse. Every request leaves as edge-triggered, whatever the trigger bit of the data word says. The destination always leaves in the 8-bit legacy form. The block only decodes fields and checks the window. Choosing the target CPU, carrying out the bus transfer and checking capability enables belong to other blocks.

A small controller with three states sequences the outputs:
- ST_IDLE: no request pending.
- ST_ISSUE: a request is presented.
- ST_REJECT: an error pulse is presented.

Every state has the same transitions:
- A strobe that hits the window moves to ST_ISSUE (transition T_HIT).
- A strobe that misses moves to ST_REJECT (transition T_MISS).
- No strobe returns to ST_IDLE (transition T_QUIET).

Top module: `irq_msg_decoder`

## Requirements
- R1: While reset is held, and after it until the first strobe, `req_valid` and `err_pulse` are both 0, and the field outputs are all 0.
- R2: A strobe whose address bits [31:20] equal 12'hFEE raises `req_valid` for exactly the one cycle after the strobe, with `err_pulse` at 0.
- R3: A strobe whose address bits [31:20] differ from 12'hFEE raises `err_pulse` for exactly the one cycle after the strobe, with `req_valid` at 0.
- R4: Address bits [63:32] take no part in the window check or in any decoded field.
- R5: `req_dest` equals address bits [19:12] of the accepted write, in 8-bit form.
- R6: `req_logical` is 1 only when address bit 3 (redirection hint) and address bit 2 (destination mode) are both 1; it is 0 (physical) for the other three combinations.
- R7: `req_vector` equals data bits [7:0], and `req_dmode` equals data bits [10:8] of the accepted write.
- R8: Data bits above bit 10, including the trigger-mode bit 15, have no effect: `req_level` is 0 (edge) on every request.
- R9: With no strobe, neither pulse is raised. Strobes on consecutive cycles give outputs on consecutive cycles, in the same order. `req_valid` and `err_pulse` are never 1 together.
- R10: A rejected write leaves `req_dest`, `req_logical`, `req_dmode` and `req_vector` at the values of the last accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a write on the address and data inputs |
| in_addr | input | 64 | Address word of the interrupt write |
| in_data | input | 64 | Data word of the interrupt write |
| req_valid | output | 1 | One-cycle delivery request to the resolver |
| req_dest | output | 8 | Destination ID, legacy 8-bit form |
| req_logical | output | 1 | 1 = logical destination, 0 = physical |
| req_dmode | output | 3 | Delivery mode code |
| req_vector | output | 8 | Interrupt vector |
| req_level | output | 1 | Trigger mode, always 0 (edge) |
| err_pulse | output | 1 | One-cycle pulse for a write outside the window |

## Verification
The assertions assume three things about the inputs:
- `in_valid` is a known value in every cycle once reset is released.
- The address and data words are meaningful only in a cycle where the strobe is high.
- A strobe can arrive in any cycle, including the cycle just after another strobe.

The stimulus drives every input on the falling clock edge and holds it for one full cycle. It returns the strobe to 0 between write bursts, and it sets the address and data to 0 while the strobe is low. The bursts mix accepted and rejected writes back to back, so that the held field values and the ordering of the pulses are both exercised.

// File: rtl/irqdec_pkg.sv
package irqdec_pkg;

    localparam int DEST_W  = 8;
    localparam int VEC_W   = 8;
    localparam int DMODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REJECT = 2'd2
    } irqdec_state_e;

    typedef struct packed {
        logic [DEST_W-1:0]  dest;
        logic               logical;
        logic [DMODE_W-1:0] dmode;
        logic [VEC_W-1:0]   vector;
    } irqdec_fields_t;

endpackage

// File: rtl/irqdec_window.sv
module irqdec_window #(
    parameter int ADDR_W = 64,
    parameter int WIN_HI = 31,
    parameter int WIN_LO = 20,
    parameter logic [WIN_HI-WIN_LO:0] WIN_BASE = 12'hFEE
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int WIN_W = WIN_HI - WIN_LO + 1;

    logic [WIN_W-1:0] win_bits;
    logic             unused_addr;

    // Only the window slice of the low half decides a hit.
    assign win_bits    = addr[WIN_HI:WIN_LO];
    assign hit         = (win_bits == WIN_BASE);
    assign unused_addr = ^addr;
endmodule

// File: rtl/irqdec_fields.sv
module irqdec_fields
    import irqdec_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int DEST_LSB  = 12,
    parameter int HINT_BIT  = 3,
    parameter int MODE_BIT  = 2,
    parameter int DMODE_LSB = 8,
    parameter int VEC_LSB   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output irqdec_fields_t    fields
);
    localparam int DEST_MSB  = DEST_LSB + DEST_W - 1;
    localparam int DMODE_MSB = DMODE_LSB + DMODE_W - 1;
    localparam int VEC_MSB   = VEC_LSB + VEC_W - 1;

    logic unused_bits;

    always_comb begin
        fields.dest    = addr[DEST_MSB:DEST_LSB];
        // Logical only when both the hint and the mode bit are set.
        fields.logical = addr[HINT_BIT] & addr[MODE_BIT];
        fields.dmode   = data[DMODE_MSB:DMODE_LSB];
        fields.vector  = data[VEC_MSB:VEC_LSB];
    end

    // Trigger bit and other upper bits are intentionally dropped.
    assign unused_bits = ^{addr, data};
endmodule

// File: rtl/irqdec_fsm.sv
module irqdec_fsm
    import irqdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic hit,
    output logic issue,
    output logic reject
);
    irqdec_state_e cur_q;
    irqdec_state_e nxt;

    always_comb begin
        nxt = ST_IDLE;
        unique case (cur_q)
            ST_IDLE, ST_ISSUE, ST_REJECT: begin
                if (in_valid) begin
                    nxt = hit ? ST_ISSUE : ST_REJECT;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= ST_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    always_comb begin
        issue  = 1'b0;
        reject = 1'b0;
        unique case (cur_q)
            ST_IDLE:   ;
            ST_ISSUE:  issue  = 1'b1;
            ST_REJECT: reject = 1'b1;
            default:   ;
        endcase
    end

    // R9: the two pulses exclude each other
    a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && reject));
endmodule

// File: rtl/irq_msg_decoder.sv
module irq_msg_decoder
    import irqdec_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int WIN_HI    = 31,
    parameter int WIN_LO    = 20,
    parameter logic [WIN_HI-WIN_LO:0] WIN_BASE = 12'hFEE,
    parameter int DEST_LSB  = 12,
    parameter int HINT_BIT  = 3,
    parameter int MODE_BIT  = 2,
    parameter int DMODE_LSB = 8,
    parameter int VEC_LSB   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              req_valid,
    output logic [DEST_W-1:0] req_dest,
    output logic              req_logical,
    output logic [DMODE_W-1:0] req_dmode,
    output logic [VEC_W-1:0]  req_vector,
    output logic              req_level,
    output logic              err_pulse
);
    localparam int DEST_MSB = DEST_LSB + DEST_W - 1;

    logic           hit;
    irqdec_fields_t fields;
    irqdec_fields_t fld_q;
    logic           issue;
    logic           reject;

    irqdec_window #(
        .ADDR_W(ADDR_W), .WIN_HI(WIN_HI), .WIN_LO(WIN_LO), .WIN_BASE(WIN_BASE)
    ) u_win (
        .addr(in_addr),
        .hit (hit)
    );

    irqdec_fields #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEST_LSB(DEST_LSB),
        .HINT_BIT(HINT_BIT), .MODE_BIT(MODE_BIT),
        .DMODE_LSB(DMODE_LSB), .VEC_LSB(VEC_LSB)
    ) u_fld (
        .addr  (in_addr),
        .data  (in_data),
        .fields(fields)
    );

    irqdec_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .hit     (hit),
        .issue   (issue),
        .reject  (reject)
    );

    // Fields load only on an accepted write (R10 keeps them on a reject).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else if (in_valid && hit) begin
            fld_q <= fields;
        end
    end

    assign req_valid   = issue;
    assign err_pulse   = reject;
    assign req_dest    = fld_q.dest;
    assign req_logical = fld_q.logical;
    assign req_dmode   = fld_q.dmode;
    assign req_vector  = fld_q.vector;
    assign req_level   = 1'b0; // R8: every request is edge-triggered

    // R2: an in-window strobe gives a request on the next cycle
    a_r2_hit_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[WIN_HI:WIN_LO] == WIN_BASE) |=> (req_valid && !err_pulse));

    // R3: an out-of-window strobe gives an error pulse on the next cycle
    a_r3_miss_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[WIN_HI:WIN_LO] != WIN_BASE) |=> (err_pulse && !req_valid));

    // R9: no strobe, no pulse
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!req_valid && !err_pulse));

    // R5: the destination follows the address slice of the accepted write
    a_r5_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[WIN_HI:WIN_LO] == WIN_BASE) |=>
            (req_dest == $past(in_addr[DEST_MSB:DEST_LSB])));

    // R6: logical only with both address bits set
    a_r6_logical: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[WIN_HI:WIN_LO] == WIN_BASE) |=>
            (req_logical == ($past(in_addr[HINT_BIT]) && $past(in_addr[MODE_BIT]))));

    // R10: a reject leaves the decoded fields untouched
    a_r10_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[WIN_HI:WIN_LO] != WIN_BASE) |=>
            ($stable(req_dest) && $stable(req_vector) && $stable(req_dmode) && $stable(req_logical)));
endmodule

// File: tb/sim_irq_msg_decoder.sv
`timescale 1ns/1ps
module sim_irq_msg_decoder;

    typedef struct packed {
        logic       is_err;
        logic [7:0] dest;
        logic       logical;
        logic [2:0] dmode;
        logic [7:0] vector;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [63:0] in_data = '0;
    logic        req_valid;
    logic [7:0]  req_dest;
    logic        req_logical;
    logic [2:0]  req_dmode;
    logic [7:0]  req_vector;
    logic        req_level;
    logic        err_pulse;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  held = '0;

    always #2.5 clk = ~clk;

    irq_msg_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_addr(in_addr), .in_data(in_data),
        .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
        .req_dmode(req_dmode), .req_vector(req_vector), .req_level(req_level),
        .err_pulse(err_pulse)
    );

    task automatic check(input bit ok, input string tag, input string got, input string want);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %s expected %s", tag, got, want);
        end
    endtask

    // Driver: presents one write for one cycle and queues the expected result.
    task automatic send(input logic [63:0] a, input logic [63:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_data  = d;
        if (a[31:20] == 12'hFEE) begin
            held.is_err  = 1'b0;
            held.dest    = a[19:12];
            held.logical = a[3] & a[2];
            held.dmode   = d[10:8];
            held.vector  = d[7:0];
            e = held;
        end else begin
            e = held;
            e.is_err = 1'b1;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_addr  = '0;
            in_data  = '0;
        end
    endtask

    // Monitor: pops the expected item whenever the design raises a pulse.
    always @(negedge clk) begin
        if (rst_n && (req_valid || err_pulse)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 spurious pulse",
                      $sformatf("valid=%0b err=%0b", req_valid, err_pulse), "no pulse");
            end else begin
                exp_t  e;
                exp_t  g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = '{is_err: err_pulse, dest: req_dest, logical: req_logical,
                      dmode: req_dmode, vector: req_vector};
                check(g == e && (req_valid != err_pulse) && req_level == 1'b0, t,
                      $sformatf("err=%0b dest=%h log=%0b dm=%0d vec=%h val=%0b lvl=%0b",
                                g.is_err, g.dest, g.logical, g.dmode, g.vector, req_valid, req_level),
                      $sformatf("err=%0b dest=%h log=%0b dm=%0d vec=%h",
                                e.is_err, e.dest, e.logical, e.dmode, e.vector));
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!req_valid && !err_pulse && req_dest == 0 && req_vector == 0, "R1 in reset",
              $sformatf("%0b%0b", req_valid, err_pulse), "00");
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && !err_pulse && req_dmode == 0 && !req_logical, "R1 after reset",
              $sformatf("%0b%0b", req_valid, err_pulse), "00");

        send(64'h0000_0000_FEE0_3000, 64'h41, "R2 R5 R7 basic accept");
        idle(3);
        send(64'h0000_0000_FEE0_5008, 64'h0123, "R6 hint only physical");
        send(64'h0000_0000_FEE0_6004, 64'h0222, "R6 mode only physical");
        send(64'h0000_0000_FEE0_700C, 64'h0333, "R6 both bits logical");
        send(64'h0000_0000_FEE0_8000, 64'h0444, "R6 neither bit physical");
        idle(2);
        send(64'hDEAD_BEEF_FEEF_F00C, 64'h0535, "R4 upper address ignored");
        send(64'h0000_0000_FED0_0000, 64'h0099, "R3 R10 below window");
        send(64'h0000_0000_FFE0_0000, 64'h0088, "R3 R10 above window");
        send(64'h0000_0FEE_0000_0000, 64'h0077, "R3 R4 window in upper half");
        idle(2);
        send(64'h0000_0000_FEE1_2000, 64'h07FF, "R7 dmode 7 vector FF");
        send(64'h0000_0000_FEE3_4000, 64'h8020, "R8 trigger bit ignored");
        send(64'hFFFF_FFFF_FEEA_B004, 64'hFFFF_FFFF_FFFF_C612, "R8 upper data ignored");
        send(64'h0000_0000_1234_5678, 64'h0011, "R9 R10 reject in burst");
        send(64'h0000_0000_FEE0_0000, 64'h0000, "R9 accept after reject");
        idle(4);
        check(exp_q.size() == 0, "R9 all results delivered",
              $sformatf("%0d left", exp_q.size()), "0 left");
        check(!req_valid && !err_pulse, "R9 quiet when idle",
              $sformatf("%0b%0b", req_valid, err_pulse), "00");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule